// File: doc/BRIEF.md
# Selectable Ratio Bus Clock Generator

This block derives the expansion-bus clock from the processor clock. A 3-bit select field (the low three bits of the bus-clock configuration register at index 20h) picks one of six fixed divide ratios. It can also pick a separate fixed-frequency reference of about 7.16 MHz, which the block passes through in place of a divided clock. The reference runs asynchronously to the processor clock. It is resynchronized by a two-flop chain before use.

A build parameter selects the output form. It is either a 50%-duty clock or a one-cycle enable pulse, one per bus period. A change of the select field is never applied mid-period. The divider takes a new ratio only when its current period ends. A move between the divider and the reference goes through a gap state that holds the output low. The new source is then joined on a clean phase boundary, so no shortened high phase is ever produced.

Top module: `busclk_gen`

## Requirements
- R1: While reset is asserted the output is low, and it stays low for at least the first two clock cycles after reset is released.
- R2: Select codes 1, 2, 3, 4, 5 and 6 (binary 001 to 110) divide the processor clock by 4, 5, 6, 8, 10 and 12 respectively. The output period equals that ratio in processor cycles.
- R3: In clock mode (OUT_MODE = 0) each divided period is low for floor(N/2) cycles and then high for ceil(N/2) cycles. For ratio 5 the high phase (3) is one cycle longer than the low phase (2).
- R4: Select code 0 (binary 000) routes the reference clock to the output through a two-flop synchronizer. The high and low phase lengths follow the reference.
- R5: Select code 7 (binary 111) behaves exactly like code 0.
- R6: A new divide ratio is applied only at the end of the current output period. The high phase in progress completes with the old ratio, and the next low phase uses the new one.
- R7: Under arbitrary select changes, every high phase has the full length of either a divide ratio or the reference. No high phase is shorter than 2 cycles.
- R8: A handover between the divider and the reference holds the output low for at least one cycle. The first high phase from the new source is full length.
- R9: In enable mode (OUT_MODE = 1) the output is a one-cycle pulse. It fires once per divided period of N cycles, and once per synchronized rising edge of the reference in reference mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selCode | input | 3 | Bus clock select field (register 20h bits 2:0) |
| refClk | input | 1 | Asynchronous fixed-frequency reference clock |
| busOut | output | 1 | Bus clock (OUT_MODE=0) or one-cycle bus enable (OUT_MODE=1) |

## Verification
The hardest situation to create is a select change that lands in the middle of a phase. This matters most when the change crosses between the divider and the reference, because the generator must then wait both for its own period end and for a low level on the synchronized reference. Directed cases change the select one cycle after an output rise, in both directions. A long random run then draws select codes and hold times of 1 to 40 cycles from a fixed seed, so changes fall at every phase position. Throughout that run, a monitor measures every completed high phase against the set of legal lengths.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

  localparam int RATIO_W = 4;   // wide enough for the largest ratio (12)
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {
    ST_GAP = 2'd0,
    ST_DIV = 2'd1,
    ST_REF = 2'd2
  } busState_t;

  typedef struct packed {
    logic holdLow;   // force output low, clear the divider
    logic useRef;    // follow the synchronized reference
  } ctlStrobes_t;

  function automatic logic isRefCode(input logic [SEL_W-1:0] code);
    return (code == 3'd0) || (code == 3'd7);
  endfunction

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [SEL_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd1:    r = 4'd4;
      3'd2:    r = 4'd5;
      3'd3:    r = 4'd6;
      3'd4:    r = 4'd8;
      3'd5:    r = 4'd10;
      3'd6:    r = 4'd12;
      default: r = 4'd4;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/busclk_ctl.sv
module busclk_ctl
  import busclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    selCode,
  input  logic                periodEnd,
  input  logic                refLow,
  input  logic                refFall,
  output ctlStrobes_t         strobes,
  output logic [RATIO_W-1:0]  ratio
);

  busState_t        state;
  logic [SEL_W-1:0] activeCode;
  logic             wantRef;

  assign wantRef = isRefCode(selCode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_GAP;
      activeCode <= '0;
    end else begin
      case (state)
        ST_GAP: begin
          activeCode <= selCode;
          if (!wantRef)    state <= ST_DIV;
          else if (refLow) state <= ST_REF;
        end
        ST_DIV: begin
          if (periodEnd) begin
            if (wantRef) state <= ST_GAP;
            else         activeCode <= selCode;
          end
        end
        ST_REF: begin
          if (refFall) begin
            if (!wantRef) state <= ST_GAP;
            else          activeCode <= selCode;
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  assign strobes.holdLow = (state == ST_GAP);
  assign strobes.useRef  = (state == ST_REF);
  assign ratio           = ratioOf(activeCode);

  // R6: the ratio in use changes only at a period end
  a_r6_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIV && !periodEnd) |=> $stable(activeCode));

endmodule

// File: rtl/busclk_dp.sv
module busclk_dp
  import busclk_pkg::*;
#(
  parameter bit OUT_MODE = 1'b0   // 0: 50% clock, 1: one-cycle enable
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               refClk,
  input  ctlStrobes_t        strobes,
  input  logic [RATIO_W-1:0] ratio,
  output logic               periodEnd,
  output logic               refLow,
  output logic               refFall,
  output logic               busOut
);

  localparam int SYNC_LEN = 3;   // two synchronizer flops plus one edge flop

  logic [SYNC_LEN-1:0] refSync;
  logic [RATIO_W-1:0]  cnt;
  logic [RATIO_W-1:0]  lowLen;
  logic                refRise;
  logic                divRun;
  logic                outQ;

  always_ff @(posedge clk) begin
    if (!rst_n) refSync <= '0;
    else        refSync <= {refSync[SYNC_LEN-2:0], refClk};
  end

  assign refLow  = !refSync[1];
  assign refFall = refSync[2] & !refSync[1];
  assign refRise = refSync[1] & !refSync[2];

  assign lowLen    = ratio >> 1;
  assign divRun    = !strobes.holdLow && !strobes.useRef;
  assign periodEnd = divRun && (cnt == ratio - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      outQ <= 1'b0;
    end else if (strobes.holdLow) begin
      cnt  <= '0;
      outQ <= 1'b0;
    end else if (strobes.useRef) begin
      cnt  <= '0;
      outQ <= OUT_MODE ? refRise : refSync[1];
    end else begin
      cnt  <= periodEnd ? '0 : cnt + 4'd1;
      outQ <= OUT_MODE ? periodEnd : (cnt >= lowLen);
    end
  end

  assign busOut = outQ;

  // R8: the gap state always produces a low output cycle
  a_r8_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.holdLow |=> !outQ);

  // R2: the divider count never reaches the ratio in use
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    divRun |-> (cnt < ratio));

  generate
    if (OUT_MODE) begin : g_enChk
      // R9: enable pulses are one cycle wide
      a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        outQ |=> !outQ);
    end
  endgenerate

endmodule

// File: rtl/busclk_gen.sv
module busclk_gen
  import busclk_pkg::*;
#(
  parameter bit OUT_MODE = 1'b0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] selCode,
  input  logic             refClk,
  output logic             busOut
);

  ctlStrobes_t        strobes;
  logic [RATIO_W-1:0] ratio;
  logic               periodEnd;
  logic               refLow;
  logic               refFall;

  busclk_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .selCode   (selCode),
    .periodEnd (periodEnd),
    .refLow    (refLow),
    .refFall   (refFall),
    .strobes   (strobes),
    .ratio     (ratio)
  );

  busclk_dp #(.OUT_MODE(OUT_MODE)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .refClk    (refClk),
    .strobes   (strobes),
    .ratio     (ratio),
    .periodEnd (periodEnd),
    .refLow    (refLow),
    .refFall   (refFall),
    .busOut    (busOut)
  );

endmodule

// File: tb/busclk_gen_tb.sv
`timescale 1ns/1ps
module busclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] selCode = 3'd1;
  logic       refClk = 1'b0;
  logic       busOut;
  logic       busEn;

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;                    // 100 MHz
  initial begin
    #2;
    forever #70 refClk = ~refClk;          // 7 processor cycles per phase
  end

  busclk_gen #(.OUT_MODE(1'b0)) u_dut   (.clk(clk), .rst_n(rst_n), .selCode(selCode), .refClk(refClk), .busOut(busOut));
  busclk_gen #(.OUT_MODE(1'b1)) u_dutEn (.clk(clk), .rst_n(rst_n), .selCode(selCode), .refClk(refClk), .busOut(busEn));

  function automatic int ratioFor(input int code);
    case (code)
      1: return 4;  2: return 5;  3: return 6;
      4: return 8;  5: return 10; 6: return 12;
      default: return 14;   // reference: full period in processor cycles
    endcase
  endfunction

  function automatic int hiLen(input int n);
    return (n + 1) / 2;
  endfunction

  function automatic int loLen(input int n);
    return n / 2;
  endfunction

  function automatic bit sampleOut(input int which);
    return (which == 0) ? busOut : busEn;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitRise(input int which);
    bit prev;
    prev = sampleOut(which);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!prev && sampleOut(which)) return;
      prev = sampleOut(which);
    end
  endtask

  // counts the run of the current level, starting at the current sample
  task automatic runLen(input int which, output int n);
    bit lvl;
    lvl = sampleOut(which);
    n = 1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (sampleOut(which) != lvl) return;
      n++;
    end
  endtask

  // random-run monitor: R7 every completed high phase has a legal length
  int hiRun = 0;
  bit armed = 1'b0;
  always @(negedge clk) begin
    if (!monOn) begin
      armed = 1'b0;
      hiRun = 0;
    end else if (busOut) begin
      hiRun++;
    end else begin
      if (armed && hiRun > 0) begin
        checks++;
        if (!(hiRun inside {2, 3, 4, 5, 6, 7})) begin
          errors++;
          $display("FAIL R7: high phase actual %0d expected one of 2..7", hiRun);
        end
      end
      armed = 1'b1;
      hiRun = 0;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h;
    int l;
    int p;
    int seedVal;
    seedVal = $urandom(32'd20240611);

    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 low in reset", busOut, 0);
    check("R1 enable low in reset", busEn, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 low first cycle", busOut, 0);
    @(negedge clk);
    check("R1 low second cycle", busOut, 0);

    // R2/R3: every divide code
    for (int c = 1; c <= 6; c++) begin
      selCode = 3'(c);
      repeat (3) waitRise(0);
      runLen(0, h);
      runLen(0, l);
      check($sformatf("R3 high code %0d", c), h, hiLen(ratioFor(c)));
      check($sformatf("R3 low code %0d", c), l, loLen(ratioFor(c)));
      check($sformatf("R2 period code %0d", c), h + l, ratioFor(c));
    end

    // R4: reference, R5: code 7 identical
    selCode = 3'd0;
    repeat (3) waitRise(0);
    runLen(0, h); runLen(0, l);
    check("R4 ref high", h, 7);
    check("R4 ref low", l, 7);
    selCode = 3'd7;
    repeat (3) waitRise(0);
    runLen(0, h); runLen(0, l);
    check("R5 code7 high", h, 7);
    check("R5 code7 low", l, 7);

    // R6: change mid-high from ratio 4 to ratio 12
    selCode = 3'd1;
    repeat (3) waitRise(0);
    selCode = 3'd6;
    runLen(0, h); runLen(0, l); runLen(0, p);
    check("R6 old high kept", h, 2);
    check("R6 new low", l, 6);
    check("R6 new high", p, 6);

    // R8: divider to reference and back
    selCode = 3'd3;
    repeat (3) waitRise(0);
    selCode = 3'd0;
    runLen(0, h); runLen(0, l); runLen(0, p);
    check("R8 last div high", h, 3);
    check("R8 gap low present", (l >= 1) ? 1 : 0, 1);
    check("R8 first ref high", p, 7);
    repeat (2) waitRise(0);
    selCode = 3'd3;
    runLen(0, h); runLen(0, l); runLen(0, p);
    check("R8 last ref high", h, 7);
    check("R8 low after ref", (l >= 1) ? 1 : 0, 1);
    check("R8 first div high", p, 3);

    // R9: enable mode
    selCode = 3'd4;
    repeat (3) waitRise(1);
    runLen(1, h); runLen(1, l);
    check("R9 pulse width", h, 1);
    check("R9 pulse spacing div8", h + l, 8);
    selCode = 3'd0;
    repeat (4) waitRise(1);
    runLen(1, h); runLen(1, l);
    check("R9 ref pulse width", h, 1);
    check("R9 ref pulse spacing", h + l, 14);

    // R7: random select changes
    waitRise(0);
    runLen(0, h);
    monOn = 1'b1;
    for (int k = 0; k < 300; k++) begin
      selCode = 3'($urandom_range(0, 7));
      repeat ($urandom_range(1, 40)) @(negedge clk);
    end
    monOn = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule